// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block performs the register save that a small 32-bit core carries out when it takes an exception, and the matching restore when the handler returns. On an accepted entry request it captures an eight-word frame from the core: the four low argument registers, R12, the link register, the return address and the status word. It then writes that frame to memory one word per accepted memory handshake and reports the new value of the stack pointer it used. Finally it switches the core into handler mode and pulses a completion flag.

The block keeps the processor mode itself, but it does not own the two stack pointers. It reads the main and process pointers from its inputs and reports the updated pointer through a one-cycle write strobe, which the surrounding core applies. The stack grows downward, and a stack pointer always addresses the last word pushed. In thread mode the control-register select bit picks the process or the main stack. In handler mode the main stack is always used, so a nested entry lands on the main stack.

At each entry a small record stack saves the mode that was left and the stack that was used. A return request pops the newest frame from that same stack, in the reverse order, hands the eight words out as a restored frame and puts the recorded mode back. The memory side is a valid/ready request channel. While `mem_valid` is high and `mem_ready` is low, the block holds `mem_write`, `mem_addr` and `mem_wdata` steady. A word counts as transferred only in a cycle where both signals are high. For reads, the memory must present `mem_rdata` in that same cycle.

Top module: `exc_stack_seq`

## Requirements
- R1: An entry writes eight words, highest address first. With old pointer S it writes slot 7 (status) at S-4, slot 6 (return address) at S-8, slot 5 (link) at S-12, slot 4 (R12) at S-16, then slots 3,2,1,0 (R3,R2,R1,R0) down to R0 at S-32. Slot k sits at bits [32k+31:32k] of `push_frame`, and each step lowers the address by 4.
- R2: The stack for an entry is chosen as follows. In thread mode (`handler_mode`=0), `ctrl_spsel`=1 selects the process pointer and `ctrl_spsel`=0 selects the main pointer. In handler mode the main pointer is used whatever `ctrl_spsel` is. `sp_wr_psp`=1 marks the process pointer.
- R3: The cycle after the last entry handshake, `entry_done` and `sp_wr_en` pulse for one cycle. `sp_wr_val` then equals S-32 for the chosen stack, and `handler_mode` reads 1.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` keep their values into the next cycle. Exactly one word moves per cycle in which both are high.
- R5: `busy` rises in the cycle after a request is accepted and stays high through the last handshake. `exc_req` and `exc_ret` are ignored while `busy` is high, and cause no further memory traffic.
- R6: A return reads eight words from the recorded stack with pointer S: R0 at S, then each higher slot at +4, ending with slot 7 at S+28. When it finishes, `return_done` and `sp_wr_en` pulse, `sp_wr_val` is S+32, and `pop_frame` holds the words read in the same slot layout as `push_frame`.
- R7: A return restores the mode recorded at its matching entry: thread (0) if the entry came from thread mode, handler (1) if it was nested.
- R8: If `exc_req` and `exc_ret` are both high in an idle cycle, the entry is taken and the return is dropped.
- R9: An entry request is ignored when NEST_DEPTH entries are outstanding. A return request is ignored when none is outstanding. In both cases there is no memory traffic, `busy` stays low and the mode is unchanged.
- R10: After reset, `busy`, `mem_valid`, `handler_mode`, `entry_done`, `return_done` and `sp_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception entry request, sampled when idle |
| exc_ret | input | 1 | Exception return request, sampled when idle |
| ctrl_spsel | input | 1 | Control-register stack select for thread mode (1 = process) |
| msp_in | input | AW | Current main stack pointer |
| psp_in | input | AW | Current process stack pointer |
| push_frame | input | 8*DW | Register values to save, slot k at bits [DW*k +: DW] |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the handshake cycle of a read |
| busy | output | 1 | Sequence in progress |
| handler_mode | output | 1 | 1 = handler mode, 0 = thread mode |
| entry_done | output | 1 | One-cycle pulse when a save completes |
| return_done | output | 1 | One-cycle pulse when a restore completes |
| sp_wr_en | output | 1 | One-cycle stack pointer update strobe |
| sp_wr_psp | output | 1 | Update targets the process pointer (else main) |
| sp_wr_val | output | AW | New stack pointer value |
| pop_frame | output | 8*DW | Frame restored by the last return |

## Verification
An entry request and a return request can arrive in the same idle cycle. The bench provokes this by pulsing both while one entry is outstanding. It judges the result by the handshake log: it must contain eight writes to the handler-mode stack and no read. The outstanding record must also survive and be popped correctly later. The second collision is a request landing inside a running sequence. The bench pulses both requests again in the middle of a stalled save. It then confirms that exactly eight handshakes occur and that the port stays quiet afterwards.

// File: rtl/exc_stk_pkg.sv
package exc_stk_pkg;
  localparam int FRAME_WORDS = 8;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PUSH,
    SQ_POP
  } sq_state_t;

  typedef struct packed {
    logic from_handler;
    logic on_psp;
  } ctx_rec_t;
endpackage

// File: rtl/exc_ctx_stack.sv
module exc_ctx_stack
  import exc_stk_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  ctx_rec_t din,
  input  logic     pop,
  output ctx_rec_t top,
  output logic     full,
  output logic     empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  ctx_rec_t      recs [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (push && !full) cnt <= cnt + 1'b1;
    else if (pop && !empty) cnt <= cnt - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) recs[i] <= '0;
      else if (push && cnt == CW'(i)) recs[i] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt == CW'(i + 1)) top = recs[i];
  end

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/exc_frame_path.sv
module exc_frame_path #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int SW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORDS*DW-1:0] frame_in,
  input  logic [SW-1:0]       slot,
  input  logic                capture,
  input  logic [DW-1:0]       rdata,
  output logic [DW-1:0]       wdata,
  output logic [WORDS*DW-1:0] frame_out
);
  logic [WORDS*DW-1:0] save_q;

  always_ff @(posedge clk) begin
    if (!rst_n) save_q <= '0;
    else if (load) save_q <= frame_in;
  end

  assign wdata = save_q[int'(slot)*DW +: DW];

  for (genvar i = 0; i < WORDS; i++) begin : g_cap
    always_ff @(posedge clk) begin
      if (!rst_n) frame_out[i*DW +: DW] <= '0;
      else if (capture && slot == SW'(i)) frame_out[i*DW +: DW] <= rdata;
    end
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_stk_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  localparam int SW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic          exc_ret,
  input  logic          ctrl_spsel,
  input  logic [AW-1:0] msp_in,
  input  logic [AW-1:0] psp_in,
  input  logic          ctx_full,
  input  logic          ctx_empty,
  input  ctx_rec_t      ctx_top,
  output logic          ctx_push,
  output ctx_rec_t      ctx_din,
  output logic          ctx_pop,
  output logic          frame_load,
  output logic [SW-1:0] slot,
  output logic          capture,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          handler_mode,
  output logic          entry_done,
  output logic          return_done,
  output logic          sp_wr_en,
  output logic          sp_wr_psp,
  output logic [AW-1:0] sp_wr_val
);
  localparam logic [AW-1:0] STEP     = AW'(DW / 8);
  localparam logic [SW-1:0] TOP_SLOT = SW'(WORDS - 1);

  sq_state_t     state;
  logic [AW-1:0] ptr;
  logic          op_psp;
  logic          restore_handler;
  logic          sel_psp, start_push, start_pop, hs, last;

  assign sel_psp    = !handler_mode && ctrl_spsel;
  assign start_push = (state == SQ_IDLE) && exc_req && !ctx_full;
  assign start_pop  = (state == SQ_IDLE) && !exc_req && exc_ret && !ctx_empty;
  assign hs         = mem_valid && mem_ready;
  assign last       = (state == SQ_PUSH) ? (slot == '0) : (slot == TOP_SLOT);

  assign busy       = (state != SQ_IDLE);
  assign mem_valid  = busy;
  assign mem_write  = (state == SQ_PUSH);
  assign mem_addr   = ptr;
  assign frame_load = start_push;
  assign capture    = hs && (state == SQ_POP);
  assign ctx_push   = hs && (state == SQ_PUSH) && last;
  assign ctx_pop    = hs && (state == SQ_POP) && last;
  assign ctx_din    = '{from_handler: handler_mode, on_psp: op_psp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= SQ_IDLE;
      ptr             <= '0;
      slot            <= '0;
      op_psp          <= 1'b0;
      restore_handler <= 1'b0;
      handler_mode    <= 1'b0;
      entry_done      <= 1'b0;
      return_done     <= 1'b0;
      sp_wr_en        <= 1'b0;
      sp_wr_psp       <= 1'b0;
      sp_wr_val       <= '0;
    end else begin
      entry_done  <= 1'b0;
      return_done <= 1'b0;
      sp_wr_en    <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start_push) begin
            state  <= SQ_PUSH;
            op_psp <= sel_psp;
            ptr    <= (sel_psp ? psp_in : msp_in) - STEP;
            slot   <= TOP_SLOT;
          end else if (start_pop) begin
            state           <= SQ_POP;
            op_psp          <= ctx_top.on_psp;
            restore_handler <= ctx_top.from_handler;
            ptr             <= ctx_top.on_psp ? psp_in : msp_in;
            slot            <= '0;
          end
        end
        SQ_PUSH: begin
          if (hs) begin
            if (last) begin
              state        <= SQ_IDLE;
              entry_done   <= 1'b1;
              handler_mode <= 1'b1;
              sp_wr_en     <= 1'b1;
              sp_wr_psp    <= op_psp;
              sp_wr_val    <= ptr;
            end else begin
              ptr  <= ptr - STEP;
              slot <= slot - 1'b1;
            end
          end
        end
        SQ_POP: begin
          if (hs) begin
            ptr <= ptr + STEP;
            if (last) begin
              state        <= SQ_IDLE;
              return_done  <= 1'b1;
              handler_mode <= restore_handler;
              sp_wr_en     <= 1'b1;
              sp_wr_psp    <= op_psp;
              sp_wr_val    <= ptr + STEP;
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
  import exc_stk_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int NEST_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      exc_req,
  input  logic                      exc_ret,
  input  logic                      ctrl_spsel,
  input  logic [AW-1:0]             msp_in,
  input  logic [AW-1:0]             psp_in,
  input  logic [FRAME_WORDS*DW-1:0] push_frame,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_write,
  output logic [AW-1:0]             mem_addr,
  output logic [DW-1:0]             mem_wdata,
  input  logic [DW-1:0]             mem_rdata,
  output logic                      busy,
  output logic                      handler_mode,
  output logic                      entry_done,
  output logic                      return_done,
  output logic                      sp_wr_en,
  output logic                      sp_wr_psp,
  output logic [AW-1:0]             sp_wr_val,
  output logic [FRAME_WORDS*DW-1:0] pop_frame
);
  localparam int SW = $clog2(FRAME_WORDS);

  ctx_rec_t      ctx_top, ctx_din;
  logic          ctx_full, ctx_empty, ctx_push, ctx_pop;
  logic          frame_load, capture;
  logic [SW-1:0] slot;

  exc_ctx_stack #(.DEPTH(NEST_DEPTH)) ctx_i (
    .clk(clk), .rst_n(rst_n), .push(ctx_push), .din(ctx_din), .pop(ctx_pop),
    .top(ctx_top), .full(ctx_full), .empty(ctx_empty)
  );

  exc_frame_path #(.WORDS(FRAME_WORDS), .DW(DW)) path_i (
    .clk(clk), .rst_n(rst_n), .load(frame_load), .frame_in(push_frame),
    .slot(slot), .capture(capture), .rdata(mem_rdata), .wdata(mem_wdata),
    .frame_out(pop_frame)
  );

  exc_seq_ctrl #(.AW(AW), .DW(DW), .WORDS(FRAME_WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_ret(exc_ret),
    .ctrl_spsel(ctrl_spsel), .msp_in(msp_in), .psp_in(psp_in),
    .ctx_full(ctx_full), .ctx_empty(ctx_empty), .ctx_top(ctx_top),
    .ctx_push(ctx_push), .ctx_din(ctx_din), .ctx_pop(ctx_pop),
    .frame_load(frame_load), .slot(slot), .capture(capture),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .busy(busy), .handler_mode(handler_mode),
    .entry_done(entry_done), .return_done(return_done), .sp_wr_en(sp_wr_en),
    .sp_wr_psp(sp_wr_psp), .sp_wr_val(sp_wr_val)
  );
endmodule

// File: rtl/exc_stack_seq_chk.sv
module exc_stack_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          handler_mode,
  input logic          entry_done,
  input logic          return_done,
  input logic          sp_wr_en,
  input logic [AW-1:0] sp_wr_val
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_write) &&
                                $stable(mem_addr) && $stable(mem_wdata));

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid ||
      (mem_write == $past(mem_write) &&
       mem_addr == ($past(mem_write) ? $past(mem_addr) - STEP : $past(mem_addr) + STEP)));

  assert_entry_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> handler_mode && sp_wr_en);

  assert_entry_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> sp_wr_val == $past(mem_addr));

  assert_return_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    return_done |-> sp_wr_en && sp_wr_val == $past(mem_addr) + STEP);

  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({entry_done, return_done}) && (sp_wr_en == (entry_done || return_done)));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done || return_done) |-> !busy && $past(busy));
endmodule

bind exc_stack_seq exc_stack_seq_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .busy(busy), .handler_mode(handler_mode), .entry_done(entry_done),
  .return_done(return_done), .sp_wr_en(sp_wr_en), .sp_wr_val(sp_wr_val)
);

// File: tb/exc_stack_seq_tb_top.sv
module exc_stack_seq_tb_top;
  localparam int DW = 32, AW = 32, DEPTH = 4, FW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, exc_req, exc_ret, ctrl_spsel, mem_ready;
  logic [AW-1:0] msp_m, psp_m;
  logic [FW*DW-1:0] push_frame, pop_frame;
  logic mem_valid, mem_write, busy, handler_mode, entry_done, return_done;
  logic sp_wr_en, sp_wr_psp;
  logic [AW-1:0] mem_addr, sp_wr_val;
  logic [DW-1:0] mem_wdata, mem_rdata;

  exc_stack_seq #(.DW(DW), .AW(AW), .NEST_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_ret(exc_ret),
    .ctrl_spsel(ctrl_spsel), .msp_in(msp_m), .psp_in(psp_m),
    .push_frame(push_frame), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .handler_mode(handler_mode),
    .entry_done(entry_done), .return_done(return_done), .sp_wr_en(sp_wr_en),
    .sp_wr_psp(sp_wr_psp), .sp_wr_val(sp_wr_val), .pop_frame(pop_frame)
  );

  logic [DW-1:0] mem [256];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  logic          log_wr   [64];
  int log_n, stall_cnt;
  bit stall_en;

  assign mem_rdata = mem[mem_addr[9:2]];

  // memory and stack pointer model, acting away from the active edge
  always @(negedge clk) begin
    stall_cnt++;
    mem_ready = !stall_en || (stall_cnt % 3 != 0);
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) mem[mem_addr[9:2]] = mem_wdata;
      if (log_n < 64) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_write ? mem_wdata : mem_rdata;
        log_wr[log_n]   = mem_write;
      end
      log_n++;
    end
    if (rst_n && sp_wr_en) begin
      if (sp_wr_psp) psp_m = sp_wr_val;
      else msp_m = sp_wr_val;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // expected model of outstanding entries
  bit mdl_handler;
  logic [FW*DW-1:0] st_frame [DEPTH];
  bit st_psp [DEPTH], st_h [DEPTH];
  int st_n, seed;

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit req, input bit ret);
    @(negedge clk);
    exc_req = req;
    exc_ret = ret;
    @(negedge clk);
    exc_req = 0;
    exc_ret = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300; i++) begin
      if (entry_done || return_done) return;
      @(negedge clk);
    end
  endtask

  task automatic push_and_check(input bit spsel, input bit with_ret, input bit poke);
    bit exp_psp;
    logic [AW-1:0] base;
    @(negedge clk);
    ctrl_spsel = spsel;
    for (int k = 0; k < FW; k++) push_frame[k*DW +: DW] = 32'hA000_0000 + seed * 256 + k;
    seed++;
    exp_psp = !mdl_handler && spsel;
    base = exp_psp ? psp_m : msp_m;
    log_n = 0;
    pulse(1'b1, with_ret);
    check("R5", "busy after accept", AW'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      pulse(1'b1, 1'b1);
    end
    wait_done();
    check("R3", "entry_done", AW'(entry_done), 1);
    check("R3", "sp_wr_en", AW'(sp_wr_en), 1);
    check("R2", "stack select", AW'(sp_wr_psp), AW'(exp_psp));
    check("R3", "new sp", sp_wr_val, base - 32);
    check("R3", "handler mode", AW'(handler_mode), 1);
    check(with_ret ? "R8" : "R1", "handshake count", AW'(log_n), 8);
    for (int i = 0; i < FW; i++) begin
      check("R1", "write addr", log_addr[i], base - 4 - 4 * i);
      check("R1", "write data", log_data[i], push_frame[(7 - i)*DW +: DW]);
      check(with_ret ? "R8" : "R1", "is write", AW'(log_wr[i]), 1);
    end
    st_frame[st_n] = push_frame;
    st_psp[st_n] = exp_psp;
    st_h[st_n] = mdl_handler;
    st_n++;
    mdl_handler = 1;
    if (poke) begin
      repeat (10) @(negedge clk);
      check("R5", "no traffic after busy pokes", AW'(log_n), 8);
      check("R5", "idle after busy pokes", AW'(busy), 0);
    end
  endtask

  task automatic pop_and_check();
    logic [AW-1:0] base;
    bit used_psp;
    st_n--;
    used_psp = st_psp[st_n];
    @(negedge clk);
    base = used_psp ? psp_m : msp_m;
    log_n = 0;
    pulse(1'b0, 1'b1);
    check("R5", "busy after return accept", AW'(busy), 1);
    wait_done();
    check("R6", "return_done", AW'(return_done), 1);
    check("R6", "sp select", AW'(sp_wr_psp), AW'(used_psp));
    check("R6", "restored sp", sp_wr_val, base + 32);
    check("R7", "restored mode", AW'(handler_mode), AW'(st_h[st_n]));
    check("R6", "read count", AW'(log_n), 8);
    for (int i = 0; i < FW; i++) begin
      check("R6", "read addr", log_addr[i], base + 4 * i);
      check("R6", "is read", AW'(log_wr[i]), 0);
      check("R6", "pop slot", pop_frame[i*DW +: DW], st_frame[st_n][i*DW +: DW]);
    end
    mdl_handler = st_h[st_n];
  endtask

  task automatic ignored_check(input bit req, input bit ret);
    @(negedge clk);
    log_n = 0;
    pulse(req, ret);
    repeat (5) @(negedge clk);
    check("R9", "no traffic", AW'(log_n), 0);
    check("R9", "not busy", AW'(busy), 0);
    check("R9", "mode unchanged", AW'(handler_mode), AW'(mdl_handler));
  endtask

  task automatic reset_check();
    check("R10", "busy", AW'(busy), 0);
    check("R10", "mem_valid", AW'(mem_valid), 0);
    check("R10", "handler_mode", AW'(handler_mode), 0);
    check("R10", "done pulses", AW'({entry_done, return_done, sp_wr_en}), 0);
  endtask

  initial begin
    rst_n = 0; exc_req = 0; exc_ret = 0; ctrl_spsel = 0; mem_ready = 1;
    stall_en = 0; stall_cnt = 0; log_n = 0; st_n = 0; seed = 1; mdl_handler = 0;
    msp_m = 32'h2000_0300; psp_m = 32'h2000_0200; push_frame = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reset_check();

    push_and_check(1'b1, 1'b0, 1'b0);   // R2 thread, process stack
    stall_en = 1;
    push_and_check(1'b1, 1'b0, 1'b1);   // R2 handler uses main, R4/R5 with stalls
    pop_and_check();                    // R7 back to handler
    pop_and_check();                    // R7 back to thread
    push_and_check(1'b0, 1'b0, 1'b0);   // R2 thread, main stack
    pop_and_check();
    stall_en = 0;
    push_and_check(1'b1, 1'b0, 1'b0);
    push_and_check(1'b1, 1'b1, 1'b0);   // R8 entry wins over return
    pop_and_check();
    pop_and_check();
    stall_en = 1;
    for (int i = 0; i < DEPTH; i++) push_and_check(1'b0, 1'b0, 1'b0);
    ignored_check(1'b1, 1'b0);          // R9 full
    for (int i = 0; i < DEPTH; i++) pop_and_check();
    ignored_check(1'b0, 1'b1);          // R9 empty

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule